// File: doc/BRIEF.md
# Four-Sided Routing Switch Box with Shadow Configuration

This block routes data between the four sides of a tile in a reconfigurable array. Each side (north, south, west, east) has its own group of input ports and its own group of output ports. Every port carries a word of `DW` bits. Each output has a small select register that picks its source from a fixed list of `P` candidate inputs. Any one input may feed as many outputs as select it. The input-to-output path is purely combinational and holds no register.

The select registers are never written directly. Behind them sits a shadow copy that forms one serial chain. A new routing is shifted into the chain one bit per clock while the box keeps routing with its current selects. A single swap pulse then exchanges the shadow and active copies in one clock edge. The routing changes at once, and the previous routing is left in the chain where it can be shifted out and saved for preemption.

Top module: `sb_switch_box`

## Requirements
- R1: While `rst_n` is low at a rising edge, all active selects and all shadow bits become 0. After reset, every output j carries input j and `scan_out` is 0.
- R2: Inputs are numbered 0..N-1 across the sides in the order north, south, west, east, ascending within each side. Outputs are numbered 0..M-1 in the same way. An output j whose select holds a code k < P carries input (j + k) mod N.
- R3: An output whose select code is P or greater drives all zeros.
- R4: Several outputs may carry the same input in the same cycle.
- R5: With `scan_en` high and `swap` low, each rising edge shifts the chain by one bit. `scan_in` enters chain bit 0 and `scan_out` shows the top bit (TOT-1, TOT = M·ceil(log2 P)). The select for output j occupies chain bits [j·SW +: SW].
- R6: Shifting the chain leaves every output unchanged.
- R7: When `swap` is high at a rising edge, the active selects take the shadow contents and the shadow takes the old active selects, both in that edge.
- R8: When `swap` and `scan_en` are both high, the swap is performed and the chain does not shift in that cycle.
- R9: An output follows a change of its selected input in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_en | input | 1 | Shift the shadow chain by one bit |
| swap | input | 1 | Exchange the shadow and active selects |
| scan_in | input | 1 | Serial bit entering chain bit 0 |
| in_n | input | NI_N·DW | North-side inputs |
| in_s | input | NI_S·DW | South-side inputs |
| in_w | input | NI_W·DW | West-side inputs |
| in_e | input | NI_E·DW | East-side inputs |
| scan_out | output | 1 | Top bit of the shadow chain |
| out_n | output | MO_N·DW | North-side outputs |
| out_s | output | MO_S·DW | South-side outputs |
| out_w | output | MO_W·DW | West-side outputs |
| out_e | output | MO_E·DW | East-side outputs |

## Verification
Two configuration actions can fall in the same cycle: the swap and a chain shift. The bench provokes this by raising `swap` and `scan_en` together while `scan_in` is 1, with the shadow holding a known routing A and the active side holding a routing B. The outcome is judged in two ways. The outputs must then route by A exactly. Shifting the chain out must then return B bit for bit, with no trace of the stray 1. The bench also checks that loading a new routing while the old one is in force leaves the outputs untouched until the swap.

// File: rtl/sb_pkg.sv
// Package: shared types for the switch box.
// Assumes: nothing beyond IEEE 1800-2017.
package sb_pkg;

    // Configuration action selected in a cycle; swap outranks shift.
    typedef enum logic [1:0] {
        CFG_HOLD  = 2'd0,
        CFG_SHIFT = 2'd1,
        CFG_SWAP  = 2'd2
    } cfg_op_e;

endpackage

// File: rtl/sb_cfg_chain.sv
// Module: shadow chain plus active select registers.
// Shifts the shadow chain one bit per cycle and exchanges shadow and
// active copies on swap. Swap has priority over shift.
// Assumes: TOT >= 2; synchronous active-low reset.
module sb_cfg_chain #(
    parameter int TOT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_en,
    input  logic           swap,
    input  logic           scan_in,
    output logic           scan_out,
    output logic [TOT-1:0] active_sel
);
    import sb_pkg::*;

    logic [TOT-1:0] shadow_q;
    logic [TOT-1:0] active_q;
    cfg_op_e        op;

    // Decode the action for this cycle.
    always_comb begin
        if (swap)         op = CFG_SWAP;
        else if (scan_en) op = CFG_SHIFT;
        else              op = CFG_HOLD;
    end

    // Update the shadow chain and the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            case (op)
                CFG_SWAP: begin
                    shadow_q <= active_q;
                    active_q <= shadow_q;
                end
                CFG_SHIFT: shadow_q <= {shadow_q[TOT-2:0], scan_in};
                default: ;
            endcase
        end
    end

    assign scan_out   = shadow_q[TOT-1];
    assign active_sel = active_q;

endmodule

// File: rtl/sb_out_mux.sv
// Module: one output selector.
// Picks candidate k = sel, i.e. input (OUT_IDX + k) mod N, when sel < P,
// otherwise drives zero. Purely combinational.
// Assumes: 2 <= P <= N.
module sb_out_mux #(
    parameter int N       = 8,
    parameter int DW      = 4,
    parameter int P       = 3,
    parameter int SW      = 2,
    parameter int OUT_IDX = 0
) (
    input  logic [N*DW-1:0] in_flat,
    input  logic [SW-1:0]   sel,
    output logic [DW-1:0]   dout
);

    // Compare the select against each candidate and forward the match.
    always_comb begin
        dout = '0;
        for (int k = 0; k < P; k++) begin
            if (sel == SW'(k)) dout = in_flat[((OUT_IDX + k) % N)*DW +: DW];
        end
    end

endmodule

// File: rtl/sb_switch_box.sv
// Module: four-sided routing switch box (top).
// Flattens the side ports, instantiates one selector per output and the
// shadow configuration chain. Data path is combinational.
// Assumes: every side has at least one input and one output; 2 <= P <= N.
module sb_switch_box #(
    parameter int DW   = 4,
    parameter int NI_N = 2,
    parameter int NI_S = 2,
    parameter int NI_W = 2,
    parameter int NI_E = 2,
    parameter int MO_N = 2,
    parameter int MO_S = 2,
    parameter int MO_W = 2,
    parameter int MO_E = 2,
    parameter int P    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             swap,
    input  logic             scan_in,
    input  logic [NI_N*DW-1:0] in_n,
    input  logic [NI_S*DW-1:0] in_s,
    input  logic [NI_W*DW-1:0] in_w,
    input  logic [NI_E*DW-1:0] in_e,
    output logic             scan_out,
    output logic [MO_N*DW-1:0] out_n,
    output logic [MO_S*DW-1:0] out_s,
    output logic [MO_W*DW-1:0] out_w,
    output logic [MO_E*DW-1:0] out_e
);
    localparam int N   = NI_N + NI_S + NI_W + NI_E;
    localparam int M   = MO_N + MO_S + MO_W + MO_E;
    localparam int SW  = (P > 1) ? $clog2(P) : 1;
    localparam int TOT = M * SW;

    logic [N*DW-1:0] in_flat;
    logic [M*DW-1:0] out_flat;
    logic [TOT-1:0]  sel_vec;

    assign in_flat = {in_e, in_w, in_s, in_n};

    sb_cfg_chain #(.TOT(TOT)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .swap       (swap),
        .scan_in    (scan_in),
        .scan_out   (scan_out),
        .active_sel (sel_vec)
    );

    for (genvar j = 0; j < M; j++) begin : g_out
        sb_out_mux #(.N(N), .DW(DW), .P(P), .SW(SW), .OUT_IDX(j)) u_mux (
            .in_flat (in_flat),
            .sel     (sel_vec[j*SW +: SW]),
            .dout    (out_flat[j*DW +: DW])
        );
    end

    assign out_n = out_flat[0                  +: MO_N*DW];
    assign out_s = out_flat[MO_N*DW            +: MO_S*DW];
    assign out_w = out_flat[(MO_N+MO_S)*DW     +: MO_W*DW];
    assign out_e = out_flat[(MO_N+MO_S+MO_W)*DW +: MO_E*DW];

endmodule

// File: rtl/sb_switch_chk.sv
// Module: temporal checks on the configuration registers of the box.
// Assumes: bound to sb_switch_box; observes the shadow chain and selects.
module sb_switch_chk #(
    parameter int TOT = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scan_en,
    input logic           swap,
    input logic           scan_in,
    input logic [TOT-1:0] shadow,
    input logic [TOT-1:0] active
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (active == '0 && shadow == '0));

    a_r5_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !swap) |=> shadow == {$past(shadow[TOT-2:0]), $past(scan_in)});

    a_r6_shift_keeps_route: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(active));

    a_r7_swap_loads: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> active == $past(shadow));

    a_r8_swap_saves: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> shadow == $past(active));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !swap) |=> $stable(shadow));

endmodule

bind sb_switch_box sb_switch_chk #(.TOT(TOT)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .swap    (swap),
    .scan_in (scan_in),
    .shadow  (u_cfg.shadow_q),
    .active  (sel_vec)
);

// File: tb/sb_switch_box_tb_top.sv
// Bench: sweeps select codes and input patterns on an 8-in / 8-out box.
module sb_switch_box_tb_top;
    localparam int DW  = 4;
    localparam int NS  = 2;
    localparam int N   = 4 * NS;
    localparam int M   = 4 * NS;
    localparam int P   = 3;
    localparam int SW  = 2;
    localparam int TOT = M * SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0;
    logic swap = 1'b0;
    logic scan_in = 1'b0;
    logic scan_out;
    logic [N*DW-1:0] din = '0;
    logic [M*DW-1:0] dout;
    logic [NS*DW-1:0] o_n, o_s, o_w, o_e;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [TOT-1:0] m_active = '0;
    logic [TOT-1:0] m_shadow = '0;

    always #2 clk = ~clk;

    sb_switch_box #(.DW(DW), .NI_N(NS), .NI_S(NS), .NI_W(NS), .NI_E(NS),
                    .MO_N(NS), .MO_S(NS), .MO_W(NS), .MO_E(NS), .P(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .swap(swap), .scan_in(scan_in),
        .in_n(din[0 +: NS*DW]), .in_s(din[NS*DW +: NS*DW]),
        .in_w(din[2*NS*DW +: NS*DW]), .in_e(din[3*NS*DW +: NS*DW]),
        .scan_out(scan_out), .out_n(o_n), .out_s(o_s), .out_w(o_w), .out_e(o_e));

    assign dout = {o_e, o_w, o_s, o_n};

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int exp_out(input int j, input logic [TOT-1:0] cfg);
        int k;
        k = int'(cfg[j*SW +: SW]);
        if (k >= P) return 0;
        return int'(din[((j + k) % N)*DW +: DW]);
    endfunction

    task automatic check_all(input string req);
        for (int j = 0; j < M; j++) check(req, int'(dout[j*DW +: DW]), exp_out(j, m_active));
    endtask

    task automatic set_pattern(input int p);
        for (int i = 0; i < N; i++) din[i*DW +: DW] = DW'((i*3 + p*5 + 1) % 16);
        #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic shift_bit(input logic b);
        scan_en = 1'b1; scan_in = b; tick(); scan_en = 1'b0; scan_in = 1'b0;
        m_shadow = {m_shadow[TOT-2:0], b};
    endtask

    task automatic load(input logic [TOT-1:0] v);
        for (int i = TOT-1; i >= 0; i--) begin
            shift_bit(v[i]);
            if (i == TOT/2) check_all("R6 mid-load outputs");
        end
    endtask

    task automatic do_swap();
        logic [TOT-1:0] t;
        swap = 1'b1; tick(); swap = 1'b0;
        t = m_active; m_active = m_shadow; m_shadow = t;
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < TOT; i++) begin
            check(req, int'(scan_out), int'(m_shadow[TOT-1]));
            shift_bit(1'b0);
        end
    endtask

    task automatic sweep(input logic [TOT-1:0] v, input string req);
        load(v);
        check_all("R6 before swap");
        do_swap();
        for (int p = 0; p < 4; p++) begin
            set_pattern(p);
            check_all(req);
        end
    endtask

    initial begin : watchdog
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [TOT-1:0] cfg;
        logic [TOT-1:0] a_cfg;
        logic [TOT-1:0] b_cfg;
        set_pattern(0);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1: reset state
        check("R1 scan_out", int'(scan_out), 0);
        for (int j = 0; j < M; j++)
            check("R1 identity route", int'(dout[j*DW +: DW]), int'(din[j*DW +: DW]));

        // R2/R3: every output on the same code, all codes
        for (int c = 0; c < 4; c++) begin
            for (int j = 0; j < M; j++) cfg[j*SW +: SW] = SW'(c);
            sweep(cfg, (c >= P) ? "R3 out-of-range zero" : "R2 candidate route");
        end

        // R2/R3: mixed codes
        for (int j = 0; j < M; j++) cfg[j*SW +: SW] = SW'((j*7 + 1) % 4);
        sweep(cfg, "R2 mixed codes");

        // R4: outputs 0,1,2 all pick input 2
        cfg = '0;
        cfg[0*SW +: SW] = 2'd2;
        cfg[1*SW +: SW] = 2'd1;
        cfg[2*SW +: SW] = 2'd0;
        for (int j = 3; j < M; j++) cfg[j*SW +: SW] = SW'(j % 3);
        sweep(cfg, "R4 fan-out");
        check("R4 out0=in2", int'(dout[0 +: DW]), int'(din[2*DW +: DW]));
        check("R4 out1=in2", int'(dout[DW +: DW]), int'(din[2*DW +: DW]));
        check("R4 out2=in2", int'(dout[2*DW +: DW]), int'(din[2*DW +: DW]));

        // R7: shadow now holds previous routing; read it back
        readback("R7 saved routing on scan_out");

        // R8: swap and shift together
        for (int j = 0; j < M; j++) a_cfg[j*SW +: SW] = SW'((j + 2) % 3);
        for (int j = 0; j < M; j++) b_cfg[j*SW +: SW] = SW'((j*5) % 4);
        load(b_cfg); do_swap();
        load(a_cfg);
        swap = 1'b1; scan_en = 1'b1; scan_in = 1'b1;
        tick();
        swap = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
        m_active = a_cfg; m_shadow = b_cfg;
        set_pattern(2);
        check_all("R8 swap wins route");
        readback("R8 no shift on collision");

        // R9: combinational follow with no clock edge
        for (int p = 4; p < 8; p++) begin
            set_pattern(p);
            check_all("R9 same-cycle follow");
        end

        // R5: shifting a single marker bit through the chain
        m_shadow = '0;
        for (int i = 0; i < TOT; i++) shift_bit(1'b0);
        shift_bit(1'b1);
        for (int i = 0; i < TOT-1; i++) begin
            check("R5 marker not yet out", int'(scan_out), 0);
            shift_bit(1'b0);
        end
        check("R5 marker at top bit", int'(scan_out), 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule